// File: doc/BRIEF.md
# RTC Control, Status and Interrupt Pin Router

This block keeps the two configuration and status bytes of a real-time clock and drives the clock's two active-low pins from them. A narrow byte port writes and reads the two registers. The control byte is at address 0Eh and the status byte is at address 0Fh. Other logic provides the rest of the inputs: single-cycle alarm-match pulses, a level that reports a stopped oscillator, and four clock-enable taps, one for each square-wave rate. The block returns the oscillator enable to the oscillator.

Pin A is an interrupt line. Pin B is either a second interrupt line or a square wave, as one control bit selects. The alarm flags always record matches. The enable bits only decide whether a set flag pulls a pin low. Software can clear a flag but can never set one.

Top module: `rtc_ctl_router`

## Requirements
- R1: After reset, the control byte reads 18h, the status byte reads 80h, `osc_en` is 1 and both pins are high.
- R2: A write to address 0Eh stores control bits 7 and 4:0. Bits 6:5 always read 0. Bit 7 set to 1 stops the oscillator, so `osc_en` equals the inverse of bit 7.
- R3: The status byte at 0Fh has the oscillator-stop flag in bit 7, the alarm-2 flag in bit 1 and the alarm-1 flag in bit 0. Bits 6:2 read 0. A written 0 clears a flag. A written 1 leaves it unchanged, so a write never sets a flag.
- R4: A pulse on `alarm1_hit` or `alarm2_hit` sets the matching flag on the next clock edge, whatever the state of the enable bits.
- R5: If a match and a clearing write fall in the same cycle, the flag ends up set.
- R6: The stop flag is set at the edge after `osc_stopped` is high or control bit 7 is 1. It stays set until it is cleared by a write.
- R7: With control bit 2 = 1, pin A is low while (alarm-1 flag AND bit 0), and pin B is low while (alarm-2 flag AND bit 1). Both are levels that last for as long as the flag stays set.
- R8: With control bit 2 = 0, pin B carries a square wave. It toggles on each pulse of the tap that bits 4:3 select: 00 = 1 Hz tap (tap 0), 01 = 4.096 kHz (tap 1), 10 = 8.192 kHz (tap 2), 11 = 32.768 kHz (tap 3). Pulses on the other taps have no effect. The wave starts high after reset.
- R9: With control bit 2 = 0, pin A is low while (alarm-1 flag AND bit 0) OR (alarm-2 flag AND bit 1).
- R10: A write to any address other than 0Eh or 0Fh changes nothing. A read of such an address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| alarm1_hit | input | 1 | Single-cycle alarm-1 match pulse |
| alarm2_hit | input | 1 | Single-cycle alarm-2 match pulse |
| osc_stopped | input | 1 | High while the oscillator is stopped |
| tap_pulse | input | 4 | Clock enables for the square-wave rates, indexed by rate code |
| osc_en | output | 1 | Oscillator run enable |
| int_a_n | output | 1 | Active-low interrupt pin A |
| sqw_intb_n | output | 1 | Active-low pin B: interrupt or square wave |

## Verification
The routing is tried with a table of control bytes and match patterns. The table covers all four enable combinations in each pin mode, with both alarms set, one alarm set or none. This separates a missing enable gate from a mode that routes alarm 2 wrongly, and it catches a pin that listens to the wrong flag. Flags are read back after every row, which shows that an enable does not stop a flag from being set.

Directed sequences then cover the following:
- A write of all ones to the status byte, which must not set any flag.
- A partial clear.
- A clear and a match in the same cycle.
- The two causes of an oscillator stop.
- Square-wave toggling on the selected tap, with pulses on other taps ignored.
- Writes to an unmapped address.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;
  localparam int DW       = 8;
  localparam int RATE_W   = 2;
  localparam int NUM_TAPS = 1 << RATE_W;

  localparam logic [DW-1:0] ADDR_CTL  = 8'h0E;
  localparam logic [DW-1:0] ADDR_STAT = 8'h0F;
  localparam logic [DW-1:0] CTL_RST   = 8'h18;
  localparam logic [DW-1:0] STAT_RST  = 8'h80;
  localparam logic [DW-1:0] CTL_KEEP  = 8'h9F;

  typedef struct packed {
    logic              osc_off;
    logic [1:0]        rsv;
    logic [RATE_W-1:0] rate;
    logic              pin_mode;
    logic              ie2;
    logic              ie1;
  } ctl_t;

  typedef struct packed {
    logic       stop;
    logic [4:0] rsv;
    logic       flag2;
    logic       flag1;
  } stat_t;

  // next value of a clear-only flag: a hardware set beats a software clear
  function automatic logic flag_next(logic q, logic wr, logic wbit, logic set);
    return set | (q & ~(wr & ~wbit));
  endfunction

  // pin A request in either mode
  function automatic logic pin_a_req(ctl_t c, stat_t s);
    return (s.flag1 & c.ie1) | (~c.pin_mode & s.flag2 & c.ie2);
  endfunction
endpackage

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wd,
  output ctl_t          ctl_q
);
  ctl_t ctl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_r <= ctl_t'(CTL_RST);
    else if (wr_hit) ctl_r <= ctl_t'(wd & CTL_KEEP);
  end

  assign ctl_q = ctl_r;

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctl_r == ctl_t'($past(wd) & CTL_KEEP)));
  // R10
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_r));
endmodule

// File: rtl/rtc_stat_flags.sv
module rtc_stat_flags
  import rtc_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wd,
  input  logic          match1,
  input  logic          match2,
  input  logic          stop_evt,
  output stat_t         stat_q
);
  logic stop_r, f2_r, f1_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_r <= STAT_RST[7];
      f2_r   <= STAT_RST[1];
      f1_r   <= STAT_RST[0];
    end else begin
      stop_r <= flag_next(stop_r, wr_hit, wd[7], stop_evt);
      f2_r   <= flag_next(f2_r,   wr_hit, wd[1], match2);
      f1_r   <= flag_next(f1_r,   wr_hit, wd[0], match1);
    end
  end

  assign stat_q = '{stop: stop_r, rsv: 5'd0, flag2: f2_r, flag1: f1_r};

  // R4 R5
  f1_set_chk: assert property (@(posedge clk) disable iff (!rst_n) match1 |=> f1_r);
  // R4 R5
  f2_set_chk: assert property (@(posedge clk) disable iff (!rst_n) match2 |=> f2_r);
  // R3
  f1_no_wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!f1_r && !match1) |=> !f1_r);
  // R3
  f1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wd[0] && !match1) |=> !f1_r);
  // R6
  stop_set_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |=> stop_r);
endmodule

// File: rtl/rtc_pin_router.sv
module rtc_pin_router
  import rtc_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctl_t                ctl,
  input  stat_t               stat,
  input  logic [NUM_TAPS-1:0] tap_pulse,
  output logic                int_a_n,
  output logic                sqw_intb_n
);
  logic sq_r;
  logic sel_tick;
  logic b_irq;

  assign sel_tick = tap_pulse[ctl.rate];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sq_r <= 1'b1;
    else if (sel_tick) sq_r <= ~sq_r;
  end

  assign b_irq      = stat.flag2 & ctl.ie2;
  assign int_a_n    = ~pin_a_req(ctl, stat);
  assign sqw_intb_n = ctl.pin_mode ? ~b_irq : sq_r;

  // R8
  sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tick |=> (sq_r != $past(sq_r)));
  // R8
  sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> $stable(sq_r));
  // R7
  b_irq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pin_mode && stat.flag2 && ctl.ie2) |-> !sqw_intb_n);
endmodule

// File: rtl/rtc_ctl_router.sv
module rtc_ctl_router
  import rtc_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          alarm1_hit,
  input  logic          alarm2_hit,
  input  logic          osc_stopped,
  input  logic [3:0]    tap_pulse,
  output logic          osc_en,
  output logic          int_a_n,
  output logic          sqw_intb_n
);
  ctl_t  ctl_q;
  stat_t stat_q;
  logic  ctl_wr, stat_wr, stop_evt;

  assign ctl_wr   = wr_en && (reg_addr == ADDR_CTL);
  assign stat_wr  = wr_en && (reg_addr == ADDR_STAT);
  assign stop_evt = osc_stopped | ctl_q.osc_off;
  assign osc_en   = ~ctl_q.osc_off;

  rtc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_hit(ctl_wr), .wd(wr_data), .ctl_q(ctl_q));

  rtc_stat_flags u_stat (
    .clk(clk), .rst_n(rst_n), .wr_hit(stat_wr), .wd(wr_data),
    .match1(alarm1_hit), .match2(alarm2_hit), .stop_evt(stop_evt), .stat_q(stat_q));

  rtc_pin_router u_pins (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .stat(stat_q), .tap_pulse(tap_pulse),
    .int_a_n(int_a_n), .sqw_intb_n(sqw_intb_n));

  always_comb begin
    if (reg_addr == ADDR_CTL)       rd_data = ctl_q;
    else if (reg_addr == ADDR_STAT) rd_data = stat_q;
    else                            rd_data = '0;
  end

  // R3
  stat_rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q.rsv == 5'd0);
  // R9
  a_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.pin_mode && stat_q.flag2 && ctl_q.ie2) |-> !int_a_n);
endmodule

// File: tb/tb_rtc_ctl_router.sv
`timescale 1ns/1ps
module tb_rtc_ctl_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       alarm1_hit = 1'b0, alarm2_hit = 1'b0, osc_stopped = 1'b0;
  logic [3:0] tap_pulse = 4'h0;
  logic       osc_en, int_a_n, sqw_intb_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_ctl_router dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .alarm1_hit(alarm1_hit), .alarm2_hit(alarm2_hit),
    .osc_stopped(osc_stopped), .tap_pulse(tap_pulse), .osc_en(osc_en),
    .int_a_n(int_a_n), .sqw_intb_n(sqw_intb_n));

  // {ctl[7:0], m1, m2, chkB, expA, expB}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {8'h07, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h05, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h06, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h04, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h06, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h03, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one write cycle; optional same-cycle match pulses
  task automatic wr(logic [7:0] a, logic [7:0] d, logic m1 = 1'b0, logic m2 = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d; alarm1_hit = m1; alarm2_hit = m2;
    @(negedge clk);
    wr_en = 1'b0; alarm1_hit = 1'b0; alarm2_hit = 1'b0;
  endtask

  task automatic pulse(logic m1, logic m2, logic [3:0] taps, logic stop);
    @(negedge clk);
    alarm1_hit = m1; alarm2_hit = m2; tap_pulse = taps; osc_stopped = stop;
    @(negedge clk);
    alarm1_hit = 1'b0; alarm2_hit = 1'b0; tap_pulse = 4'h0; osc_stopped = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = rd_data;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic       b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h0E, v); chk("R1 ctl", v, 8'h18);
    rd(8'h0F, v); chk("R1 stat", v, 8'h80);
    chk("R1 osc_en", {7'd0, osc_en}, 8'h01);
    chk("R1 pins", {6'd0, int_a_n, sqw_intb_n}, 8'h03);

    // R7 R9 R4 routing table
    for (int i = 0; i < NV; i++) begin
      wr(8'h0F, 8'h00);
      wr(8'h0E, VEC[i][12:5]);
      pulse(VEC[i][4], VEC[i][3], 4'h0, 1'b0);
      chk($sformatf("R7/R9 pinA row%0d", i), {7'd0, int_a_n}, {7'd0, VEC[i][1]});
      if (VEC[i][2])
        chk($sformatf("R7 pinB row%0d", i), {7'd0, sqw_intb_n}, {7'd0, VEC[i][0]});
      rd(8'h0F, v);
      chk($sformatf("R4 flags row%0d", i), v, {6'd0, VEC[i][3], VEC[i][4]});
    end

    // R7 level: pin stays low while flag held
    wr(8'h0F, 8'h00);
    wr(8'h0E, 8'h05);
    pulse(1'b1, 1'b0, 4'h0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 level hold", {7'd0, int_a_n}, 8'h00);
    wr(8'h0F, 8'h02);
    chk("R7 release", {7'd0, int_a_n}, 8'h01);

    // R10 unmapped address
    wr(8'h10, 8'hFF);
    rd(8'h10, v); chk("R10 read zero", v, 8'h00);
    rd(8'h0E, v); chk("R10 ctl untouched", v, 8'h05);
    rd(8'h0F, v); chk("R10 stat untouched", v, 8'h00);

    // R3 write of ones never sets; partial clear
    wr(8'h0F, 8'hFF);
    rd(8'h0F, v); chk("R3 ones no set", v, 8'h00);
    pulse(1'b1, 1'b1, 4'h0, 1'b0);
    wr(8'h0F, 8'h02);
    rd(8'h0F, v); chk("R3 partial clear", v, 8'h02);

    // R5 set beats same-cycle clear
    wr(8'h0F, 8'h00, 1'b1, 1'b0);
    rd(8'h0F, v); chk("R5 set wins", v, 8'h01);

    // R6 oscillator stop input
    wr(8'h0F, 8'h00);
    pulse(1'b0, 1'b0, 4'h0, 1'b1);
    repeat (3) @(negedge clk);
    rd(8'h0F, v); chk("R6 stop input sticky", v, 8'h80);

    // R2 R6 control write of all ones
    wr(8'h0F, 8'h00);
    wr(8'h0E, 8'hFF);
    rd(8'h0E, v); chk("R2 ctl mask", v, 8'h9F);
    chk("R2 osc_en off", {7'd0, osc_en}, 8'h00);
    @(negedge clk);
    rd(8'h0F, v); chk("R6 stop by ctl bit", v, 8'h80);
    wr(8'h0E, 8'h08);
    chk("R2 osc_en on", {7'd0, osc_en}, 8'h01);

    // R8 square wave on tap 1, other taps ignored
    b0 = sqw_intb_n;
    pulse(1'b0, 1'b0, 4'b0010, 1'b0);
    chk("R8 toggle tap1", {7'd0, sqw_intb_n}, {7'd0, ~b0});
    pulse(1'b0, 1'b0, 4'b1101, 1'b0);
    chk("R8 other taps ignored", {7'd0, sqw_intb_n}, {7'd0, ~b0});
    pulse(1'b0, 1'b0, 4'b0010, 1'b0);
    chk("R8 toggle back", {7'd0, sqw_intb_n}, {7'd0, b0});
    wr(8'h0E, 8'h18);
    pulse(1'b0, 1'b0, 4'b1000, 1'b0);
    chk("R8 tap3 toggle", {7'd0, sqw_intb_n}, {7'd0, ~b0});
    pulse(1'b0, 1'b0, 4'b0111, 1'b0);
    chk("R8 tap3 others ignored", {7'd0, sqw_intb_n}, {7'd0, ~b0});

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule